// File: doc/BRIEF.md
# Supply Front-End Control Register with I2C Slave

This block is a two-wire serial slave that owns one 8-bit control/status register for a power-and-signalling front end. A host writes the register to choose the output level, cable-drop compensation, tone mode, current-limit threshold, limiter style and the main enable. The same register, read back, also returns two live diagnostic flags: output overload and over-temperature.

The serial lines are sampled in the system clock domain through a two-flop synchroniser, and edges are found there. For this reason the system clock must run at least eight times faster than SCL. The slave answers one of four 7-bit addresses. The upper five address bits are fixed and a 2-bit strap input sets the lower two. The slave drives a single pull-down enable for SDA, and the pad supplies the open-drain behaviour.

While the undervoltage-lockout input is high, the slave does not acknowledge and the register is forced to zero.

Top module: `ctrl_reg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address {00010, addr_sel_i[1:0]}, sent MSB first, followed by an R/W bit where 1 means read. Any other address gets no ACK and leaves the register unchanged.
- R2: Register layout, MSB to LSB: ctrl_o[5] (limiter style), ctrl_o[4] (current threshold), ctrl_o[3] (tone enable), ctrl_o[2] (cable compensation), ctrl_o[1] (voltage select), ctrl_o[0] (enable), then over-temperature flag (bit 1) and overload flag (bit 0). A write of byte D sets ctrl_o to D[7:2].
- R3: Written values at bits 1 and 0 are ignored. Those bits always read as the live flag_ovt_i and flag_ovl_i.
- R4: A read sends the register MSB first. A master ACK on the ninth clock starts another copy of the byte. A master NACK ends the read, and SDA stays released until the next START.
- R5: While uvlo_i is high, no byte is acknowledged and ctrl_o is held at zero. The register is still zero after uvlo_i falls.
- R6: After reset, ctrl_o is zero and SDA is released.
- R7: After an address byte that matches, and after each write data byte, SDA is held low for the whole ninth SCL high period. The slave changes SDA only while SCL is low.
- R8: A STOP or a repeated START at any point returns the engine to idle and discards any partial byte. A repeated START begins a new address phase.
- R9: In a write with several data bytes, each byte is applied in turn, so the last complete byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus |
| addr_sel_i | input | 2 | Strap value for the low two address bits |
| uvlo_i | input | 1 | Undervoltage lockout; high blocks ACK and clears the register |
| flag_ovl_i | input | 1 | Live overload flag, read at bit 0 |
| flag_ovt_i | input | 1 | Live over-temperature flag, read at bit 1 |
| sda_pull_o | output | 1 | High drives SDA low |
| ctrl_o | output | 6 | Control bits; bit 5 = register bit 7 |

## Verification
Every slave reaction lands three system clocks after the SCL edge that causes it: two synchroniser flops plus the state register. So the ACK pull-down and each new read bit appear about three cycles after an SCL fall, and a written byte reaches ctrl_o about three cycles after the eighth SCL fall. The bench keeps SCL low and high for ten cycles each. It checks the ACK one cycle after the ninth SCL rise and again one cycle before its fall, so the check covers the full pulse. It reads data bits in the middle of the high phase and looks at ctrl_o only after a complete byte plus its ACK. After a change on uvlo_i it waits four cycles before checking the cleared register.

// File: rtl/ctrl_i2c_pkg.sv
package ctrl_i2c_pkg;
  localparam int REG_W  = 8;
  localparam int FLAG_W = 2;
  localparam int CTRL_W = REG_W - FLAG_W;
  localparam int CNT_W  = $clog2(REG_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } i2c_st_e;
endpackage

// File: rtl/i2c_sync_edge.sv
module i2c_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import ctrl_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              uvlo_i,
  input  logic [6:0]        slave_addr_i,
  input  logic [REG_W-1:0]  rd_byte_i,
  output logic              wr_en_o,
  output logic [CTRL_W-1:0] wr_data_o,
  output logic              sda_pull_o
);
  i2c_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] rx_q, tx_q;
  logic             full_q, rw_q, mack_q;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (uvlo_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i) begin
            rx_q  <= {rx_q[REG_W-2:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) full_q <= 1'b1;
          end else if (scl_fall_i && full_q) begin
            full_q <= 1'b0;
            if (state_q == ST_WR) begin
              state_q <= ST_WR_ACK;
            end else if (rx_q[REG_W-1:1] == slave_addr_i) begin
              state_q <= ST_ADDR_ACK;
              rw_q    <= rx_q[0];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD;
              tx_q    <= rd_byte_i;
            end else begin
              state_q <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) state_q <= ST_WR;
        end
        ST_RD: begin
          if (scl_fall_i) begin
            tx_q  <= {tx_q[REG_W-2:0], 1'b1};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_RD_ACK;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_q <= ST_RD;
              tx_q    <= rd_byte_i;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o    = (state_q == ST_WR) && scl_fall_i && full_q && !uvlo_i && !start_i && !stop_i;
  assign wr_data_o  = rx_q[REG_W-1 -: CTRL_W];
  assign sda_pull_o = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                      ((state_q == ST_RD) && !tx_q[REG_W-1]);

  // R5: no ACK while lockout is held
  assert_no_ack_uvlo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(uvlo_i) && uvlo_i) |-> !sda_pull_o);

  // R7: slave SDA changes only while SCL is low
  assert_pull_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i) && !uvlo_i && !$past(uvlo_i)) |-> $stable(sda_pull_o));
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import ctrl_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uvlo_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_o <= '0;
    else if (uvlo_i) ctrl_o <= '0;
    else if (we_i)   ctrl_o <= wdata_i;
  end

  // R5: lockout clears register
  assert_uvlo_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (ctrl_o == '0));

  // R1: register moves only on an accepted write
  assert_hold_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !uvlo_i) |=> $stable(ctrl_o));
endmodule

// File: rtl/ctrl_reg_i2c_slave.sv
module ctrl_reg_i2c_slave
  import ctrl_i2c_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  ADDR_BASE   = 5'b00010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel_i,
  input  logic              uvlo_i,
  input  logic              flag_ovl_i,
  input  logic              flag_ovt_i,
  output logic              sda_pull_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [CTRL_W-1:0] wr_data;
  logic [REG_W-1:0]  rd_byte;

  i2c_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign rd_byte = {ctrl_o, flag_ovt_i, flag_ovl_i};

  i2c_slave_fsm u_fsm (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .uvlo_i,
    .slave_addr_i({ADDR_BASE, addr_sel_i}),
    .rd_byte_i(rd_byte),
    .wr_en_o(wr_en), .wr_data_o(wr_data),
    .sda_pull_o
  );

  ctrl_reg u_reg (
    .clk_i, .rst_ni, .uvlo_i,
    .we_i(wr_en), .wdata_i(wr_data),
    .ctrl_o
  );

  // R8: a STOP leaves SDA released
  assert_stop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o);
endmodule

// File: tb/sim_ctrl_reg_i2c_slave.sv
module sim_ctrl_reg_i2c_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic uvlo = 1'b0, ovl = 1'b0, ovt = 1'b0;
  logic sda_pull;
  logic [5:0] ctrl;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ctrl_reg_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .uvlo_i(uvlo), .flag_ovl_i(ovl), .flag_ovt_i(ovt),
    .sda_pull_o(sda_pull), .ctrl_o(ctrl)
  );

  // {strap, write data, ovt, ovl, expected read byte}
  localparam logic [19:0] VEC [4] = '{
    {2'd0, 8'hA5, 1'b0, 1'b1, 8'hA5},
    {2'd1, 8'hFF, 1'b1, 1'b0, 8'hFE},
    {2'd2, 8'h00, 1'b1, 1'b1, 8'h03},
    {2'd3, 8'h5A, 1'b0, 1'b0, 8'h58}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    b = sda_line;
    repeat (H - H/2) @(negedge clk);
    scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  // ack = {early sample, late sample} of the ninth clock high phase
  task automatic write_byte(input logic [7:0] d, output logic [1:0] ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    @(negedge clk); ack[1] = sda_line;
    repeat (H - 2) @(negedge clk); ack[0] = sda_line;
    @(negedge clk); scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [7:0] d, output logic [1:0] a_ad, output logic [1:0] a_d);
    i2c_start();
    write_byte({5'b00010, sel, 1'b0}, a_ad);
    write_byte(d, a_d);
    i2c_stop();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] a1, a2, a3;
    logic [7:0] rb, rb2;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 reset ctrl", {2'b00, ctrl}, 8'h00);
    chk("R6 reset sda", {7'd0, sda_pull}, 8'h00);

    // table walk: R1 strap, R2 layout, R3 flags, R7 ack
    for (int v = 0; v < 4; v++) begin
      addr_sel = VEC[v][19:18];
      ovt = VEC[v][9];
      ovl = VEC[v][8];
      do_write(VEC[v][19:18], VEC[v][17:10], a1, a2);
      chk("R7 addr ack", {6'd0, a1}, 8'h00);
      chk("R7 data ack", {6'd0, a2}, 8'h00);
      chk("R2 ctrl_o", {2'b00, ctrl}, {2'b00, VEC[v][17:12]});
      i2c_start();
      write_byte({5'b00010, VEC[v][19:18], 1'b1}, a1);
      read_byte(1'b0, rb);
      i2c_stop();
      chk("R1 read addr ack", {6'd0, a1}, 8'h00);
      chk("R3 readback", rb, VEC[v][7:0]);
    end

    // R1: other address ignored
    addr_sel = 2'd0; ovt = 1'b0; ovl = 1'b0;
    do_write(2'd0, 8'h24, a1, a2);
    chk("R1 setup", {2'b00, ctrl}, 8'h09);
    do_write(2'd1, 8'hFC, a1, a2);
    chk("R1 foreign nack", {6'd0, a1}, 8'h03);
    chk("R1 foreign no change", {2'b00, ctrl}, 8'h09);
    i2c_start(); write_byte(8'h30, a1); write_byte(8'hFC, a2); i2c_stop();
    chk("R1 base mismatch nack", {6'd0, a1}, 8'h03);
    chk("R1 base mismatch no change", {2'b00, ctrl}, 8'h09);

    // R3: flag positions written as 1 are ignored
    do_write(2'd0, 8'h83, a1, a2);
    chk("R3 ctrl from write", {2'b00, ctrl}, 8'h20);
    ovt = 1'b0; ovl = 1'b0;
    i2c_start(); write_byte(8'h11, a1); read_byte(1'b0, rb); i2c_stop();
    chk("R3 flags not stored", rb, 8'h80);

    // R9: multi-byte write, last wins
    i2c_start();
    write_byte(8'h10, a1);
    write_byte(8'h44, a2);
    chk("R9 first byte applied", {2'b00, ctrl}, 8'h11);
    write_byte(8'hC8, a3);
    i2c_stop();
    chk("R9 last byte ack", {6'd0, a3}, 8'h00);
    chk("R9 last wins", {2'b00, ctrl}, 8'h32);

    // R4: read continues on ACK, stops on NACK
    ovt = 1'b1; ovl = 1'b0;
    i2c_start(); write_byte(8'h11, a1);
    read_byte(1'b1, rb);
    read_byte(1'b0, rb2);
    chk("R4 first byte", rb, 8'hCA);
    chk("R4 repeat byte", rb2, 8'hCA);
    read_byte(1'b0, rb);
    chk("R4 released after nack", rb, 8'hFF);
    i2c_stop();

    // R8: STOP mid-byte discards partial data
    i2c_start(); write_byte(8'h10, a1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    chk("R8 stop discards", {2'b00, ctrl}, 8'h32);

    // R8: repeated START mid-byte, new transfer accepted
    i2c_start(); write_byte(8'h10, a1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    i2c_start();
    write_byte(8'h10, a1);
    write_byte(8'h18, a2);
    i2c_stop();
    chk("R8 restart ack", {6'd0, a1}, 8'h00);
    chk("R8 restart applies", {2'b00, ctrl}, 8'h06);

    // R5: undervoltage lockout
    uvlo = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 cleared", {2'b00, ctrl}, 8'h00);
    do_write(2'd0, 8'hFC, a1, a2);
    chk("R5 no addr ack", {6'd0, a1}, 8'h03);
    chk("R5 held zero", {2'b00, ctrl}, 8'h00);
    uvlo = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 zero after release", {2'b00, ctrl}, 8'h00);
    do_write(2'd0, 8'hFC, a1, a2);
    chk("R5 ack after release", {6'd0, a1}, 8'h00);
    chk("R5 write after release", {2'b00, ctrl}, 8'h3F);

    summary();
    $finish;
  end
endmodule